// File: doc/BRIEF.md
# Constant-Off-Time Current Chopper for One H-Bridge

This block is the digital part of a current regulator for a single full bridge that drives one motor winding. While the bridge is enabled, it switches on the diagonal pair that the phase input selects. It keeps that pair on until an external comparator reports that the winding current is above its reference. It then runs an off phase of fixed length, in which the current recirculates, and turns the pair back on. Every interval is a parameter given in clock cycles: the comparator blanking after turn-on, the minimum on time, the dead time and the off interval.

The off phase takes one of two patterns. In fast decay, both conducting switches open. After a dead time, only the low-side switch of the leg whose high side was driving is closed, so the winding current cannot reverse. In slow decay, only the conducting low-side switch opens. After a dead time, the second high-side switch is closed, so the current circulates through the upper half of the bridge. Each change of switch pattern that would hand a leg from one switch to the other passes through a dead-time interval. A second copy of the block serves the other winding.

Top module: `chop_ctrl`

## Requirements
- R1: With the bridge on and no phase change, the off phase has three steps: a turn-off dead time of DEAD_CYC cycles (state code 2), a recirculation step of OFF_CYC cycles (state code 3), and a turn-on dead time of DEAD_CYC cycles (state code 4). The on state (state code 1) then returns. The whole off phase lasts 2*DEAD_CYC+OFF_CYC cycles.
- R2: During the first BLANK_CYC cycles of each on state, the comparator input is ignored. A pulse in that window does not end the on state.
- R3: The on state lasts at least MIN_ON_CYC cycles. A comparator pulse that arrives after blanking but before that time still ends the on state, exactly when MIN_ON_CYC is reached.
- R4: In the on state, phase 1 drives hs1 and ls2, and phase 0 drives hs2 and ls1. All other gates are low.
- R5: Fast decay (slow_decay sampled 0) turns all gates off in both dead-time steps. During recirculation, only the low side of the leg whose high side conducted is driven: ls1 for phase 1, ls2 for phase 0.
- R6: Slow decay (slow_decay sampled 1) keeps only the conducting high side on in both dead-time steps. During recirculation, both hs1 and hs2 are on.
- R7: The decay mode is sampled on the cycle the on state ends. Changes to slow_decay during an off phase do not affect that off phase.
- R8: Reset, or enable sampled low, gives state code 0 and all gates low from the next cycle. When enable is sampled high in state 0, the on state follows in the next cycle with the phase sampled then.
- R9: A phase input that differs from the phase in use is acted on in the on state or at the end of the turn-on dead time. The block enters state code 5 with all gates low for DEAD_CYC cycles, then enters the on state with the new phase.
- R10: Neither leg ever has both its switches on. A low side rises only if its own high side was low in the previous cycle, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Bridge enable; low forces all switches off |
| phase | input | 1 | Selects the diagonal pair used in the on state |
| slow_decay | input | 1 | 1 selects slow decay, 0 fast decay |
| over_ref | input | 1 | Comparator flag: winding current above reference |
| hs1 | output | 1 | High-side gate, leg 1 |
| ls1 | output | 1 | Low-side gate, leg 1 |
| hs2 | output | 1 | High-side gate, leg 2 |
| ls2 | output | 1 | Low-side gate, leg 2 |
| state_o | output | 3 | Current sequencer state code |

## Verification
Every input is sampled on a rising edge. The state code and all four gates change together on that same edge, because the gates are registered from the next-state decode and do not lag the state. A comparator level or phase change applied in a given cycle is therefore visible one cycle later. A timed step of N cycles shows its successor exactly N cycles after it is entered. The bench drives inputs on the falling edge. It advances a behavioural model on each rising edge and compares state and gates on the next falling edge. Pulses aimed at a given on-state cycle are placed by counting falling edges from the first falling edge at which the on state is seen, which is on-cycle 0.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [2:0] {
    ST_DIS      = 3'd0,
    ST_ON       = 3'd1,
    ST_DEAD_OFF = 3'd2,
    ST_RECIRC   = 3'd3,
    ST_DEAD_ON  = 3'd4,
    ST_SWAP     = 3'd5
  } chop_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/chop_seq.sv
module chop_seq
  import chop_pkg::*;
#(
  parameter int OFF_CYC    = 1000,
  parameter int BLANK_CYC  = 100,
  parameter int DEAD_CYC   = 100,
  parameter int MIN_ON_CYC = 250
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic        phase,
  input  logic        slow_decay,
  input  logic        over_ref,
  output chop_state_e state_q,
  output chop_state_e st_d,
  output logic        ph_d,
  output logic        md_d
);
  localparam int LIM  = imax(BLANK_CYC, MIN_ON_CYC);
  localparam int TOPV = imax(LIM, imax(OFF_CYC, DEAD_CYC));
  localparam int CW   = $clog2(TOPV + 1);
  localparam logic [CW-1:0] LIM_V   = CW'(LIM);
  localparam logic [CW-1:0] BLANK_V = CW'(BLANK_CYC);
  localparam logic [CW-1:0] RIPE_V  = CW'(MIN_ON_CYC - 1);
  localparam logic [CW-1:0] DEAD_V1 = CW'(DEAD_CYC - 1);
  localparam logic [CW-1:0] OFF_V1  = CW'(OFF_CYC - 1);

  logic [CW-1:0] on_k;
  logic [CW-1:0] tmr_val;
  logic          tmr_load, tmr_done;
  logic          trip_q, ph_q, md_q, hit, ripe;

  chop_timer #(.W(CW)) i_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  assign hit  = over_ref && (on_k >= BLANK_V);
  assign ripe = (on_k >= RIPE_V);

  always_comb begin
    st_d     = state_q;
    ph_d     = ph_q;
    md_d     = md_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (!en) begin
      st_d = ST_DIS;
    end else begin
      unique case (state_q)
        ST_DIS: begin
          st_d = ST_ON;
          ph_d = phase;
        end
        ST_ON: begin
          if (phase != ph_q) begin
            st_d = ST_SWAP; ph_d = phase; tmr_load = 1'b1; tmr_val = DEAD_V1;
          end else if ((trip_q || hit) && ripe) begin
            st_d = ST_DEAD_OFF; md_d = slow_decay; tmr_load = 1'b1; tmr_val = DEAD_V1;
          end
        end
        ST_DEAD_OFF: if (tmr_done) begin
          st_d = ST_RECIRC; tmr_load = 1'b1; tmr_val = OFF_V1;
        end
        ST_RECIRC: if (tmr_done) begin
          st_d = ST_DEAD_ON; tmr_load = 1'b1; tmr_val = DEAD_V1;
        end
        ST_DEAD_ON: if (tmr_done) begin
          if (phase != ph_q) begin
            st_d = ST_SWAP; ph_d = phase; tmr_load = 1'b1; tmr_val = DEAD_V1;
          end else begin
            st_d = ST_ON;
          end
        end
        ST_SWAP: if (tmr_done) st_d = ST_ON;
        default: st_d = ST_DIS;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_DIS;
      ph_q    <= 1'b0;
      md_q    <= 1'b0;
      trip_q  <= 1'b0;
      on_k    <= '0;
    end else begin
      state_q <= st_d;
      ph_q    <= ph_d;
      md_q    <= md_d;
      if (state_q != ST_ON)    trip_q <= 1'b0;
      else if (hit)            trip_q <= 1'b1;
      if (state_q != ST_ON)    on_k <= '0;
      else if (on_k < LIM_V)   on_k <= on_k + 1'b1;
    end
  end

  // R8: a low enable always lands in the disabled state
  p_disable_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (state_q == ST_DIS));
  // R3: the on state is never left for the off phase before its minimum time
  p_min_on_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ON && st_d == ST_DEAD_OFF) |-> (on_k >= RIPE_V));
endmodule

// File: rtl/chop_gate.sv
module chop_gate
  import chop_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  chop_state_e st_d,
  input  logic        ph_d,
  input  logic        md_d,
  output logic        hs1,
  output logic        ls1,
  output logic        hs2,
  output logic        ls2
);
  logic hs1_d, ls1_d, hs2_d, ls2_d;

  always_comb begin
    hs1_d = 1'b0; ls1_d = 1'b0; hs2_d = 1'b0; ls2_d = 1'b0;
    unique case (st_d)
      ST_ON: begin
        if (ph_d) begin hs1_d = 1'b1; ls2_d = 1'b1; end
        else      begin hs2_d = 1'b1; ls1_d = 1'b1; end
      end
      ST_DEAD_OFF, ST_DEAD_ON: begin
        if (md_d) begin
          hs1_d = ph_d;
          hs2_d = !ph_d;
        end
      end
      ST_RECIRC: begin
        if (md_d) begin hs1_d = 1'b1; hs2_d = 1'b1; end
        else begin
          ls1_d = ph_d;
          ls2_d = !ph_d;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs1 <= 1'b0; ls1 <= 1'b0; hs2 <= 1'b0; ls2 <= 1'b0;
    end else begin
      hs1 <= hs1_d; ls1 <= ls1_d; hs2 <= hs2_d; ls2 <= ls2_d;
    end
  end

  // R10: no leg conducts through both switches
  p_leg1_excl_r10: assert property (@(posedge clk) disable iff (rst) !(hs1 && ls1));
  p_leg2_excl_r10: assert property (@(posedge clk) disable iff (rst) !(hs2 && ls2));
  // R10: a switch closes only after its leg partner was open a cycle
  p_ls1_gap_r10: assert property (@(posedge clk) disable iff (rst) $rose(ls1) |-> !$past(hs1));
  p_hs1_gap_r10: assert property (@(posedge clk) disable iff (rst) $rose(hs1) |-> !$past(ls1));
  p_ls2_gap_r10: assert property (@(posedge clk) disable iff (rst) $rose(ls2) |-> !$past(hs2));
  p_hs2_gap_r10: assert property (@(posedge clk) disable iff (rst) $rose(hs2) |-> !$past(ls2));
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
#(
  parameter int OFF_CYC    = 1000,
  parameter int BLANK_CYC  = 100,
  parameter int DEAD_CYC   = 100,
  parameter int MIN_ON_CYC = 250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       phase,
  input  logic       slow_decay,
  input  logic       over_ref,
  output logic       hs1,
  output logic       ls1,
  output logic       hs2,
  output logic       ls2,
  output logic [2:0] state_o
);
  chop_state_e state_q, st_d;
  logic        ph_d, md_d;

  chop_seq #(
    .OFF_CYC(OFF_CYC), .BLANK_CYC(BLANK_CYC),
    .DEAD_CYC(DEAD_CYC), .MIN_ON_CYC(MIN_ON_CYC)
  ) i_seq (
    .clk(clk), .rst(rst), .en(en), .phase(phase), .slow_decay(slow_decay),
    .over_ref(over_ref), .state_q(state_q), .st_d(st_d), .ph_d(ph_d), .md_d(md_d)
  );

  chop_gate i_gate (
    .clk(clk), .rst(rst), .st_d(st_d), .ph_d(ph_d), .md_d(md_d),
    .hs1(hs1), .ls1(ls1), .hs2(hs2), .ls2(ls2)
  );

  assign state_o = state_q;

  // R8: gates are all open while the state reads disabled
  p_dis_gates_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DIS) |-> !(hs1 || ls1 || hs2 || ls2));
  // R9: during a phase swap every switch is open
  p_swap_gates_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SWAP) |-> !(hs1 || ls1 || hs2 || ls2));
endmodule

// File: tb/test_chop_ctrl.sv
module test_chop_ctrl;
  localparam int OFF = 12, BLK = 4, DT = 3, MON = 7;

  logic clk = 1'b0, rst = 1'b1;
  logic en = 1'b0, phase = 1'b1, slow_decay = 1'b0, over_ref = 1'b0;
  logic hs1, ls1, hs2, ls2;
  logic [2:0] state_o;

  chop_ctrl #(.OFF_CYC(OFF), .BLANK_CYC(BLK), .DEAD_CYC(DT), .MIN_ON_CYC(MON)) i_chop_ctrl (
    .clk(clk), .rst(rst), .en(en), .phase(phase), .slow_decay(slow_decay),
    .over_ref(over_ref), .hs1(hs1), .ls1(ls1), .hs2(hs2), .ls2(ls2), .state_o(state_o)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0, overlaps = 0;
  int on_run = 0, off_run = 0, last_on = 0, last_off = 0;
  bit finished = 0;

  // behavioural reference model
  int m_st = 0, m_t = 0;
  bit m_ph = 0, m_md = 0, m_trip = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_g(input int st, input bit ph, input bit md);
    case (st)
      1: return ph ? 4'b1001 : 4'b0110;
      2, 4: return md ? (ph ? 4'b1000 : 4'b0010) : 4'b0000;
      3: return md ? 4'b1010 : (ph ? 4'b0100 : 4'b0001);
      default: return 4'b0000;
    endcase
  endfunction

  always @(posedge clk) begin
    int n;
    bit hit;
    cycles++;
    if (rst) begin
      m_st = 0; m_t = 0; m_ph = 0; m_md = 0; m_trip = 0;
    end else begin
      n = m_st;
      if (!en) n = 0;
      else case (m_st)
        0: begin n = 1; m_ph = phase; end
        1: begin
          hit = over_ref && (m_t >= BLK);
          if (phase != m_ph) begin n = 5; m_ph = phase; end
          else if ((m_trip || hit) && m_t >= MON - 1) begin n = 2; m_md = slow_decay; end
          else if (hit) m_trip = 1;
        end
        2: if (m_t == DT - 1) n = 3;
        3: if (m_t == OFF - 1) n = 4;
        4: if (m_t == DT - 1) begin
             if (phase != m_ph) begin n = 5; m_ph = phase; end else n = 1;
           end
        5: if (m_t == DT - 1) n = 1;
        default: n = 0;
      endcase
      if (n != m_st) begin m_t = 0; if (n == 1) m_trip = 0; end
      else m_t++;
      m_st = n;
    end
  end

  // per-cycle comparison and run-length monitor
  always @(negedge clk) begin
    string tg;
    logic [3:0] g, e;
    if (!rst && !finished) begin
      g = {hs1, ls1, hs2, ls2};
      e = exp_g(m_st, m_ph, m_md);
      chk(state_o == 3'(m_st), "R1 state sequence", int'(state_o), m_st);
      case (m_st)
        1: tg = "R4 on pattern";
        2, 3, 4: tg = m_md ? "R6 slow decay" : "R5 fast decay";
        5: tg = "R9 swap";
        default: tg = "R8 disabled";
      endcase
      chk(g == e, tg, int'(g), int'(e));
      if ((hs1 && ls1) || (hs2 && ls2)) overlaps++;
      if (state_o == 3'd1) on_run++;
      else if (on_run != 0) begin last_on = on_run; on_run = 0; end
      if (state_o >= 3'd2 && state_o <= 3'd4) off_run++;
      else if (off_run != 0) begin last_off = off_run; off_run = 0; end
    end
  end

  always @(posedge clk) begin
    if (cycles > 20000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_state(input logic [2:0] s);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (state_o == s) return;
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic fresh_on();
    en = 1'b0; cyc(2); en = 1'b1; wait_state(3'd1);
  endtask

  initial begin
    cyc(3);
    chk(state_o == 3'd0 && {hs1, ls1, hs2, ls2} == 4'b0, "R8 reset state", int'(state_o), 0);
    rst = 1'b0;
    cyc(2);
    chk(state_o == 3'd0, "R8 idle while disabled", int'(state_o), 0);
    en = 1'b1;
    cyc(1);
    chk(state_o == 3'd1 && {hs1, ls1, hs2, ls2} == 4'b1001, "R8 enable to on", int'({hs1, ls1, hs2, ls2}), 9);
    cyc(30);
    chk(state_o == 3'd1, "R1 stays on without trip", int'(state_o), 1);

    // R2: pulse inside the blanking window
    fresh_on();
    cyc(2); over_ref = 1'b1; cyc(1); over_ref = 1'b0;
    cyc(15);
    chk(state_o == 3'd1, "R2 blanked pulse ignored", int'(state_o), 1);

    // R3: pulse after blanking, before the minimum on time
    fresh_on();
    cyc(5); over_ref = 1'b1; cyc(1); over_ref = 1'b0;
    wait_state(3'd2); cyc(2);
    chk(last_on == MON, "R3 on time held to minimum", last_on, MON);
    wait_state(3'd1); cyc(2);
    chk(last_off == 2 * DT + OFF, "R1 off phase length", last_off, 2 * DT + OFF);

    // R3: comparator held high from turn-on
    fresh_on();
    over_ref = 1'b1;
    wait_state(3'd2); over_ref = 1'b0; cyc(2);
    chk(last_on == MON, "R3 immediate trip length", last_on, MON);

    // R7: slow decay, mode changed during recirculation
    wait_state(3'd1);
    slow_decay = 1'b1; over_ref = 1'b1;
    wait_state(3'd3);
    over_ref = 1'b0; slow_decay = 1'b0;
    cyc(3);
    chk({hs1, ls1, hs2, ls2} == 4'b1010, "R7 mode latched for off phase", int'({hs1, ls1, hs2, ls2}), 10);
    wait_state(3'd1);

    // R9: phase change while on
    phase = 1'b0;
    cyc(1);
    chk(state_o == 3'd5, "R9 swap entered", int'(state_o), 5);
    cyc(DT);
    chk(state_o == 3'd1 && {hs1, ls1, hs2, ls2} == 4'b0110, "R4 phase 0 pattern", int'({hs1, ls1, hs2, ls2}), 6);

    // fast decay with phase 0, phase change during off phase
    cyc(MON); over_ref = 1'b1;
    wait_state(3'd3); over_ref = 1'b0;
    cyc(1);
    chk({hs1, ls1, hs2, ls2} == 4'b0001, "R5 phase 0 rectification", int'({hs1, ls1, hs2, ls2}), 1);
    phase = 1'b1;
    wait_state(3'd5);
    chk(state_o == 3'd5, "R9 swap after off phase", int'(state_o), 5);
    wait_state(3'd1); cyc(1);
    chk({hs1, ls1, hs2, ls2} == 4'b1001, "R9 new phase applied", int'({hs1, ls1, hs2, ls2}), 9);

    // R8: disable in the middle of recirculation
    slow_decay = 1'b1; cyc(MON); over_ref = 1'b1;
    wait_state(3'd3); over_ref = 1'b0; cyc(2);
    en = 1'b0; cyc(1);
    chk(state_o == 3'd0 && {hs1, ls1, hs2, ls2} == 4'b0, "R8 disable mid off phase", int'({hs1, ls1, hs2, ls2}), 0);
    en = 1'b1; cyc(40);

    chk(overlaps == 0, "R10 no leg overlap", overlaps, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule